// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Flags

This block turns an asynchronous serial line into received bytes. The line is high when idle. A character is a low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The line is timed by a sampling enable pulse that runs at sixteen times the bit rate. A falling edge starts a character. The line is sampled again at the middle of the start bit to confirm it. Each later bit is sampled at its own middle.

When a character completes, the byte is placed on the output and a ready flag rises. A parity mismatch or a low stop bit raises an error flag in the same cycle as the ready flag. The error flags are sticky. They survive any number of later good characters, and only the clear-status command removes them. Reading the byte with the read strobe drops the ready flag. The clear-status command leaves the ready flag alone.

After a character whose stop bit was low, the receiver waits for the line to go high before it looks for the next start edge.

Top module: `serial_rx_sticky`

## Requirements
- R1: After reset, rx_ready, par_err and frm_err are 0 and rx_byte is 0x00.
- R2: A frame is received as a start bit and eight data bits, each sampled at mid-bit on the 16x enable with the first data bit as bit 0. After the stop bit, rx_byte holds the data and rx_ready is 1.
- R3: A low pulse that is already high again at the middle of the start bit (8 enables after the edge) is rejected. No character is produced, and the next real frame is received correctly.
- R4: par_mode encodings are 0 even, 1 odd, 2 forced 0, 3 forced 1, and 4 to 7 no parity. In modes 0 to 3 a parity bit follows the data. If that bit differs from the expected value, par_err rises in the same cycle that rx_ready rises for that character.
- R5: In the no-parity modes, no parity bit is expected: the stop bit directly follows data bit 7, and par_err is never set.
- R6: Once set, par_err stays 1 across later characters with correct parity until clr_err is pulsed.
- R7: A stop bit sampled as 0 sets frm_err in the same cycle that rx_ready rises. The receiver then waits for the line to return high before it accepts a new start bit.
- R8: Once set, frm_err stays 1 across later good characters until clr_err is pulsed.
- R9: A one-cycle rd_stb clears rx_ready on the next cycle. clr_err has no effect on rx_ready.
- R10: A one-cycle clr_err, with no character completing in that cycle, clears both par_err and frm_err on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Sampling enable at 16x the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| par_mode | input | 3 | Parity mode (0 even, 1 odd, 2 forced 0, 3 forced 1, 4-7 none) |
| rd_stb | input | 1 | Read strobe for the received byte, clears rx_ready |
| clr_err | input | 1 | Clear-status command for the error flags |
| rx_byte | output | 8 | Last received byte |
| rx_ready | output | 1 | A received byte is waiting |
| par_err | output | 1 | Sticky parity-error flag |
| frm_err | output | 1 | Sticky framing-error flag |

## Verification
The data byte, rx_ready and both error flags are due together. They appear one clock after the enable that samples the middle of the stop bit, which is a two-flop synchronizer plus roughly 8 enables into that bit. The bench therefore waits until the whole stop bit and two idle bit times have passed before it compares them. The effects of rd_stb and clr_err are due one clock after the strobe. Each check is made on the falling clock edge that follows that update, so no result depends on process order at the rising edge.

// File: rtl/rx_pkg.sv
// Shared definitions for the serial receiver: parity mode codes and
// the helpers that decode them. Assumes a 3-bit mode field.
package rx_pkg;

    typedef enum logic [2:0] {
        PAR_EVEN  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_SPACE = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_NONE  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BREAK
    } rx_state_e;

    // True when the mode expects a parity bit after the data.
    function automatic logic par_enabled(input logic [2:0] mode);
        return (mode < 3'(PAR_NONE));
    endfunction

    // Expected parity bit, given the mode and the XOR of all data bits.
    function automatic logic par_expected(input logic [2:0] mode, input logic data_xor);
        logic res;
        case (mode)
            3'(PAR_EVEN):  res = data_xor;
            3'(PAR_ODD):   res = ~data_xor;
            3'(PAR_SPACE): res = 1'b0;
            3'(PAR_MARK):  res = 1'b1;
            default:       res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/rx_sync.sv
// Two-or-more-flop synchronizer for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to 1.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rx_frame.sv
// Frame sequencer: finds and confirms the start bit, samples the data
// bits LSB first, the optional parity bit and the stop bit at mid-bit.
// It emits a one-cycle done pulse with the byte and the error results.
// Assumes os_tick pulses OSR times per bit and par_mode is held steady
// for the length of a frame.
module rx_frame
    import rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx,
    input  logic [2:0]        par_mode,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);

    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [DATA_W-1:0] shreg;
    logic              pbit;

    // Walk the frame one oversample tick at a time and report the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            data  <= '0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (os_tick) begin
                case (state)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (!rx) state <= ST_START;
                    end
                    ST_START: begin
                        if (cnt == MID_CNT) begin
                            cnt  <= '0;
                            bitn <= '0;
                            state <= rx ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST_CNT) begin
                            cnt   <= '0;
                            shreg <= {rx, shreg[DATA_W-1:1]};
                            if (bitn == LAST_BIT)
                                state <= par_enabled(par_mode) ? ST_PAR : ST_STOP;
                            else
                                bitn <= bitn + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST_CNT) begin
                            cnt   <= '0;
                            pbit  <= rx;
                            state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST_CNT) begin
                            cnt   <= '0;
                            done  <= 1'b1;
                            data  <= shreg;
                            ferr  <= ~rx;
                            perr  <= par_enabled(par_mode) &&
                                     (pbit != par_expected(par_mode, ^shreg));
                            state <= rx ? ST_IDLE : ST_BREAK;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BREAK: begin
                        if (rx) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_status.sv
// Holding register and status flags. Ready is set by a completed frame
// and cleared by a read. The error flags are sticky, set together with
// ready, and cleared only by the clear-status command. A completing
// frame takes priority over a clear in the same cycle.
module rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data_in,
    input  logic              perr_in,
    input  logic              ferr_in,
    input  logic              rd_stb,
    input  logic              clr_err,
    output logic [DATA_W-1:0] data_out,
    output logic              ready,
    output logic              perr,
    output logic              ferr
);

    // Capture the received byte when a frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_out <= '0;
        else if (done) data_out <= data_in;
    end

    // Ready flag: set on completion, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      ready <= 1'b0;
        else if (done)   ready <= 1'b1;
        else if (rd_stb) ready <= 1'b0;
    end

    // Sticky parity-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                perr <= 1'b0;
        else if (done && perr_in)  perr <= 1'b1;
        else if (clr_err)          perr <= 1'b0;
    end

    // Sticky framing-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                ferr <= 1'b0;
        else if (done && ferr_in)  ferr <= 1'b1;
        else if (clr_err)          ferr <= 1'b0;
    end

endmodule

// File: rtl/serial_rx_sticky.sv
// Top level of the serial receiver: synchronizer, frame sequencer and
// status register in series. Assumes an external 16x sampling enable.
module serial_rx_sticky #(
    parameter int DATA_W    = 8,
    parameter int OSR       = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_line,
    input  logic [2:0]        par_mode,
    input  logic              rd_stb,
    input  logic              clr_err,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              par_err,
    output logic              frm_err
);

    logic              rx_s;
    logic              frame_done;
    logic [DATA_W-1:0] frame_data;
    logic              frame_perr;
    logic              frame_ferr;

    rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .rx      (rx_s),
        .par_mode(par_mode),
        .done    (frame_done),
        .data    (frame_data),
        .perr    (frame_perr),
        .ferr    (frame_ferr)
    );

    rx_status #(.DATA_W(DATA_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (frame_done),
        .data_in (frame_data),
        .perr_in (frame_perr),
        .ferr_in (frame_ferr),
        .rd_stb  (rd_stb),
        .clr_err (clr_err),
        .data_out(rx_byte),
        .ready   (rx_ready),
        .perr    (par_err),
        .ferr    (frm_err)
    );

endmodule

// File: rtl/serial_rx_sticky_chk.sv
// Checker for the serial receiver status behaviour, bound to the top.
module serial_rx_sticky_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        par_mode,
    input logic              rd_stb,
    input logic              clr_err,
    input logic              frame_done,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_ready,
    input logic              par_err,
    input logic              frm_err
);

    // R4
    par_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> (rx_ready && $past(frame_done)));

    // R5
    par_none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> ($past(par_mode) < 3'd4));

    // R6
    par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !clr_err) |=> par_err);

    // R7
    frm_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_err) |-> (rx_ready && $past(frame_done)));

    // R8
    frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_err && !clr_err) |=> frm_err);

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !frame_done) |=> !rx_ready);

    // R9
    clr_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_stb) |=> rx_ready);

    // R10
    clr_errors_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !frame_done) |=> (!par_err && !frm_err));

    // R2
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(rx_byte));

endmodule

bind serial_rx_sticky serial_rx_sticky_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_mode  (par_mode),
    .rd_stb    (rd_stb),
    .clr_err   (clr_err),
    .frame_done(frame_done),
    .rx_byte   (rx_byte),
    .rx_ready  (rx_ready),
    .par_err   (par_err),
    .frm_err   (frm_err)
);

// File: tb/serial_rx_sticky_tb.sv
// Bench: a vector table of frames walked by one loop, then directed
// tests for start-bit glitch rejection and read behaviour.
module serial_rx_sticky_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       os_tick;
    logic       rx_line;
    logic [2:0] par_mode;
    logic       rd_stb;
    logic       clr_err;
    logic [7:0] rx_byte;
    logic       rx_ready;
    logic       par_err;
    logic       frm_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [1:0] tdiv = 2'd0;

    always #5 clk = ~clk;

    // Sampling enable: one pulse every 4 clocks (64 clocks per bit).
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign os_tick = (tdiv == 2'd3);

    serial_rx_sticky u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .rx_line (rx_line),
        .par_mode(par_mode),
        .rd_stb  (rd_stb),
        .clr_err (clr_err),
        .rx_byte (rx_byte),
        .rx_ready(rx_ready),
        .par_err (par_err),
        .frm_err (frm_err)
    );

    // Vector: {mode[2:0], data[7:0], bad_parity, stop_bit, clear_after, 2'b00}
    localparam logic [15:0] VEC [9] = '{
        {3'd0, 8'hA5, 1'b0, 1'b1, 1'b0, 2'b00},
        {3'd1, 8'h3C, 1'b1, 1'b1, 1'b0, 2'b00},
        {3'd0, 8'h81, 1'b0, 1'b1, 1'b1, 2'b00},
        {3'd3, 8'h00, 1'b1, 1'b1, 1'b0, 2'b00},
        {3'd2, 8'hFF, 1'b0, 1'b1, 1'b1, 2'b00},
        {3'd4, 8'h5A, 1'b1, 1'b1, 1'b0, 2'b00},
        {3'd0, 8'h12, 1'b0, 1'b0, 1'b0, 2'b00},
        {3'd1, 8'h7E, 1'b0, 1'b1, 1'b1, 2'b00},
        {3'd7, 8'hC3, 1'b0, 1'b0, 1'b1, 2'b00}
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_line = b;
        repeat (64) @(negedge clk);
    endtask

    function automatic logic exp_parity(input logic [2:0] m, input logic [7:0] d);
        case (m)
            3'd0: return ^d;
            3'd1: return ~^d;
            3'd2: return 1'b0;
            3'd3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_frame(input logic [2:0] m, input logic [7:0] d,
                              input logic badp, input logic stopb);
        par_mode = m;
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (m < 3'd4) send_bit(exp_parity(m, d) ^ badp);
        send_bit(stopb);
        rx_line = 1'b1;
        repeat (128) @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic exp_pe;
        logic exp_fe;
        exp_pe   = 1'b0;
        exp_fe   = 1'b0;
        rst_n    = 1'b0;
        rx_line  = 1'b1;
        par_mode = 3'd0;
        rd_stb   = 1'b0;
        clr_err  = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "rx_ready", {7'd0, rx_ready}, 8'd0);
        check("R1", "par_err",  {7'd0, par_err},  8'd0);
        check("R1", "frm_err",  {7'd0, frm_err},  8'd0);
        check("R1", "rx_byte",  rx_byte,          8'h00);

        // R2 R4 R5 R6 R7 R8 R9 R10: table of frames
        for (int v = 0; v < 9; v++) begin
            logic [2:0] m;
            logic [7:0] d;
            logic       bp, sb, cl;
            {m, d, bp, sb, cl} = VEC[v][15:2];
            send_frame(m, d, bp, sb);
            if (m < 3'd4 && bp) exp_pe = 1'b1;   // R4, R5 (none ignores)
            if (!sb) exp_fe = 1'b1;              // R7
            check("R2", "rx_ready after frame", {7'd0, rx_ready}, 8'd1);
            check("R2", "rx_byte",              rx_byte,          d);
            check("R6", "par_err",              {7'd0, par_err},  {7'd0, exp_pe});
            check("R8", "frm_err",              {7'd0, frm_err},  {7'd0, exp_fe});
            if (cl) begin
                pulse_clr();
                exp_pe = 1'b0;
                exp_fe = 1'b0;
                check("R10", "par_err after clear", {7'd0, par_err},  8'd0);
                check("R10", "frm_err after clear", {7'd0, frm_err},  8'd0);
                check("R9",  "ready kept by clear", {7'd0, rx_ready}, 8'd1);
            end
            pulse_rd();
            check("R9", "rx_ready after read", {7'd0, rx_ready}, 8'd0);
        end

        // R3: short low glitch on the idle line is rejected
        par_mode = 3'd0;
        rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (256) @(negedge clk);
        check("R3", "no char after glitch", {7'd0, rx_ready}, 8'd0);
        check("R3", "byte unchanged",       rx_byte,          8'hC3);
        send_frame(3'd0, 8'h69, 1'b0, 1'b1);
        check("R3", "frame after glitch ready", {7'd0, rx_ready}, 8'd1);
        check("R3", "frame after glitch byte",  rx_byte,          8'h69);
        check("R4", "good even parity clean",   {7'd0, par_err},  8'd0);

        // R9: read then clear with nothing pending leaves ready low
        pulse_rd();
        pulse_clr();
        check("R9", "ready stays low", {7'd0, rx_ready}, 8'd0);

        // R5: none mode, then a frame whose data would fail even parity
        send_frame(3'd5, 8'h01, 1'b0, 1'b1);
        check("R5", "none mode byte",    rx_byte,         8'h01);
        check("R5", "none mode par_err", {7'd0, par_err}, 8'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule